// File: doc/BRIEF.md
# Text-Mode Character Pixel Generator

This block turns a character screen into a one-bit pixel stream. The screen is 80 columns by 40 rows of character cells, and each glyph is 8 pixels wide and 12 scanlines tall, so the text area is 640x480 pixels. A separate raster timing unit supplies a pulse on the last pixel of every line, a pulse on the last line of every frame, and a blanking flag. The block tracks the beam position with its own counters: pixel within glyph, glyph scanline, text column and text row.

For every cell the block reads a 7-bit character code from an internal character buffer. It uses that code and the current scanline to read one 8-bit row from an internal font table, then shifts that row out one bit per pixel clock, most significant bit first. Both reads are issued ahead of time so that the first pixel of each glyph lands exactly on its cell boundary. Reads for the first cell of the next line happen during the last cell of the current line. The first cell of the next frame is fetched into a separate holding register. A host loads characters through a simple write port that is independent of the display reads.

Top module: `text_char_gen`

## Requirements
- R1: Inside the text area, and with `blank` low, `pix` equals bit (7 - x mod 8) of the font row for the cell at column x/8 and row y/12, at scanline y mod 12. Here x is the pixel count since the last line-end pulse and y is the line count since the last frame-end pulse, both starting at 0.
- R2: The code shown in a cell is the buffer entry at address row*80 + column. Buffer entries are 7 bits wide.
- R3: The font table holds 128 glyphs of 12 rows and is addressed by code*12 + scanline. The row for code c at scanline s is the byte {c[6:0], 1} XOR {s[3:0], s[3:0]}.
- R4: The cycle after a `line_end` pulse is pixel 0 of column 0. The scanline advances by one per line, and after scanline 11 it returns to 0 and the row advances.
- R5: A `line_end` pulse that comes together with `frame_end` starts the next cycle at row 0, scanline 0, column 0, showing cell 0 correctly on its first pixel, whatever the frame length was.
- R6: `pix` is 0 in every cycle in which `blank` is high.
- R7: `pix` is 0 at every position outside the 640x480 text area: pixels 640 and beyond on a line, and lines 480 and beyond in a frame.
- R8: A host write with `wr_en` high stores `wr_code` at `wr_addr` on that clock edge. The new code is shown from the next fetch of that cell onward, and cells not written keep displaying correctly while writes happen.
- R9: While `rst_n` is low, and during the first glyph after reset, `pix` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_end | input | 1 | High on the last pixel of each line |
| frame_end | input | 1 | High together with line_end on the last line of a frame |
| blank | input | 1 | Forces the output dark in this cycle |
| wr_en | input | 1 | Host character write strobe |
| wr_addr | input | 12 | Host character cell address (row*80 + column) |
| wr_code | input | 7 | Host character code |
| pix | output | 1 | Monochrome pixel output |

## Verification
The hardest case to reach is the seam between two frames. Cell 0 has to appear on the very first pixel after a frame-end pulse, but the block cannot know in advance that the current line is the last one. The bench therefore changes the frame length between frames and compares every pixel of the frame that follows. It also writes cells in the middle of the displayed frame, including cells on rows that have not yet been drawn. A reduced-size second instance is run for whole frames, so that the lines below the text area are reached within a short run.

// File: rtl/text_char_gen.sv
module text_char_gen #(
  parameter int COLS = 80,
  parameter int ROWS = 40,
  parameter int GW   = 8,
  parameter int GH   = 12,
  parameter int CW   = 7,
  localparam int AW  = $clog2(COLS*ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_end,
  input  logic          frame_end,
  input  logic          blank,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_code,
  output logic          pix
);
  localparam int CELLS  = COLS*ROWS;
  localparam int FONT_N = (1 << CW) * GH;
  localparam int FAW    = $clog2(FONT_N);
  localparam int XW     = $clog2(COLS+1);
  localparam int YW     = $clog2(ROWS+1);
  localparam int PW     = $clog2(GW);
  localparam int SW     = $clog2(GH);

  logic [PW-1:0] px;
  logic [XW-1:0] col;
  logic [SW-1:0] crow;
  logic [YW-1:0] row;
  logic [GW-1:0] shreg, font_q, home_q;
  logic [CW-1:0] code_q;
  logic [SW-1:0] fcrow_q;

  logic [CW-1:0] cbuf [CELLS];
  logic [GW-1:0] font [FONT_N];

  function automatic logic [GW-1:0] glyph_row(input int c, input int s);
    logic [GW-1:0] a, b;
    a = GW'((c << 1) | 1);
    b = GW'(s * 17);
    return a ^ b;
  endfunction

  initial begin
    for (int i = 0; i < FONT_N; i++) font[i] = glyph_row(i / GH, i % GH);
  end

  wire h_in     = col < XW'(COLS);
  wire in_area  = h_in && (row < YW'(ROWS));
  wire last_col = col == XW'(COLS-1);
  wire slot_cell = h_in && px == PW'(GW-3);
  wire slot_font = h_in && px == PW'(GW-2);
  wire slot_load = h_in && px == PW'(GW-1);
  wire slot_home = last_col && px == PW'(GW-6);
  wire slot_hfnt = last_col && px == PW'(GW-5);

  logic [YW-1:0] nx_row;
  logic [SW-1:0] nx_crow;
  logic [XW-1:0] nx_col;
  always_comb begin
    nx_row  = row;
    nx_crow = crow;
    nx_col  = col + XW'(1);
    if (last_col) begin
      nx_col = '0;
      if (crow == SW'(GH-1)) begin
        nx_crow = '0;
        nx_row  = row + YW'(1);
      end else begin
        nx_crow = crow + SW'(1);
      end
    end
  end

  wire          f_ok   = nx_row < YW'(ROWS);
  wire [AW-1:0] f_addr = AW'(nx_row) * AW'(COLS) + AW'(nx_col);
  wire [FAW-1:0] g_addr = FAW'(code_q) * FAW'(GH) + FAW'(fcrow_q);
  wire [FAW-1:0] h_addr = FAW'(code_q) * FAW'(GH);

  always_ff @(posedge clk) begin
    if (wr_en && wr_addr < AW'(CELLS)) cbuf[wr_addr] <= wr_code;
    if (slot_home) code_q <= cbuf[0];
    else if (slot_cell) begin
      code_q  <= f_ok ? cbuf[f_addr] : '0;
      fcrow_q <= nx_crow;
    end
    if (slot_hfnt) home_q <= font[h_addr];
    if (slot_font) font_q <= font[g_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      px <= '0;
      col <= '0;
      crow <= '0;
      row <= '0;
      shreg <= '0;
    end else begin
      if (line_end) begin
        px  <= '0;
        col <= '0;
        if (frame_end) begin
          crow <= '0;
          row  <= '0;
        end else if (row < YW'(ROWS)) begin
          if (crow == SW'(GH-1)) begin
            crow <= '0;
            row  <= row + YW'(1);
          end else begin
            crow <= crow + SW'(1);
          end
        end
      end else if (px == PW'(GW-1)) begin
        px <= '0;
        if (h_in) col <= col + XW'(1);
      end else begin
        px <= px + PW'(1);
      end

      if (line_end && frame_end) shreg <= home_q;
      else if (slot_load)        shreg <= font_q;
      else if (h_in)             shreg <= shreg << 1;
    end
  end

  assign pix = shreg[GW-1] & in_area & ~blank;
endmodule

// File: rtl/text_char_gen_chk.sv
module text_char_gen_chk #(
  parameter int COLS = 80,
  parameter int ROWS = 40,
  parameter int GW   = 8,
  parameter int GH   = 12,
  localparam int XW  = $clog2(COLS+1),
  localparam int YW  = $clog2(ROWS+1),
  localparam int PW  = $clog2(GW),
  localparam int SW  = $clog2(GH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          line_end,
  input logic          frame_end,
  input logic          blank,
  input logic          pix,
  input logic [PW-1:0] px,
  input logic [XW-1:0] col,
  input logic [SW-1:0] crow,
  input logic [YW-1:0] row
);
  p_blank_dark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> !pix);

  p_outside_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (col >= XW'(COLS) || row >= YW'(ROWS)) |-> !pix);

  p_line_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (px == '0 && col == '0));

  p_frame_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && frame_end) |=> (row == '0 && crow == '0));

  p_row_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && !frame_end && row < YW'(ROWS) && crow == SW'(GH-1))
      |=> (crow == '0 && row == $past(row) + YW'(1)));

  p_scan_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    crow < SW'(GH));
endmodule

bind text_char_gen text_char_gen_chk #(.COLS(COLS), .ROWS(ROWS), .GW(GW), .GH(GH)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_end(line_end), .frame_end(frame_end),
  .blank(blank), .pix(pix), .px(px), .col(col), .crow(crow), .row(row)
);

// File: tb/text_char_gen_tb.sv
module text_char_gen_tb;
  localparam int PERIOD = 10;
  localparam int LINE   = 644;
  localparam int SLINE  = 40;
  localparam int SFRAME = 40;

  logic clk = 0;
  logic rst_n = 0;
  logic line_end = 0, frame_end = 0, blank = 0;
  logic wr_en = 0;
  logic [11:0] wr_addr = 0;
  logic [6:0] wr_code = 0;
  logic pix;
  logic s_le = 0, s_fe = 0, s_wr = 0;
  logic [3:0] s_addr = 0;
  logic [6:0] s_code = 0;
  logic s_pix;

  always #(PERIOD/2) clk = ~clk;

  text_char_gen u_dut (.clk(clk), .rst_n(rst_n), .line_end(line_end), .frame_end(frame_end),
    .blank(blank), .wr_en(wr_en), .wr_addr(wr_addr), .wr_code(wr_code), .pix(pix));

  text_char_gen #(.COLS(4), .ROWS(3)) u_small (.clk(clk), .rst_n(rst_n), .line_end(s_le),
    .frame_end(s_fe), .blank(1'b0), .wr_en(s_wr), .wr_addr(s_addr), .wr_code(s_code), .pix(s_pix));

  int tests = 0, fails = 0;
  int mem [3200];
  int hx = 0, vy = 0, fl = 25, sx = 0, sy = 0;
  bit cmp_en = 0, blank_mode = 0, s_on = 0;
  int bad = 0, fx = 0, fy = 0, fa = 0, fe = 0;
  int s_dark_bad = 0, s_lit = 0;

  function automatic logic [7:0] fbyte(int c, int s);
    return 8'((c << 1) | 1) ^ 8'(s * 17);
  endfunction

  function automatic bit exp_pix(int x, int y, bit b);
    logic [7:0] r;
    if (x >= 640 || y >= 480 || b) return 1'b0;
    r = fbyte(mem[(y/12)*80 + x/8], y % 12);
    return r[7 - (x % 8)];
  endfunction

  task automatic check(bit ok, string req, int act, int expv, string what);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      line_end  = (hx == LINE-1);
      frame_end = (hx == LINE-1) && (vy == fl-1);
      blank     = blank_mode && ((hx / 3) % 4 == 1);
      s_le      = (sx == SLINE-1);
      s_fe      = (sx == SLINE-1) && (sy == SFRAME-1);
      #1;
      if (cmp_en) begin
        bit e;
        e = exp_pix(hx, vy, blank);
        if (pix !== e) begin
          if (bad == 0) begin fx = hx; fy = vy; fa = int'(pix); fe = int'(e); end
          bad++;
        end
      end
      if (s_on) begin
        if (sy >= 36 || sx >= 32) begin if (s_pix !== 1'b0) s_dark_bad++; end
        else if (s_pix === 1'b1) s_lit++;
      end
      if (hx == LINE-1) begin
        hx = 0;
        vy = (vy == fl-1) ? 0 : vy + 1;
      end else hx++;
      if (sx == SLINE-1) begin
        sx = 0;
        sy = (sy == SFRAME-1) ? 0 : sy + 1;
      end else sx++;
    end
  end

  task automatic wait_frame();
    do tick(); while (!(hx == 0 && vy == 0));
  endtask

  task automatic compare_frame(string req, string what);
    wait_frame();
    bad = 0;
    cmp_en = 1;
    wait_frame();
    cmp_en = 0;
    check(bad == 0, req, fa, fe, $sformatf("%s first mismatch x=%0d y=%0d, %0d pixels", what, fx, fy, bad));
  endtask

  task automatic t_reset_r9();
    repeat (3) @(posedge clk);
    #3 check(pix === 1'b0, "R9", int'(pix), 0, "pix during reset");
    @(posedge clk); #2 rst_n = 1;
    begin
      int lit = 0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk); #2;
        if (pix !== 1'b0) lit++;
      end
      check(lit == 0, "R9", lit, 0, "lit pixels in first glyph after reset");
    end
  endtask

  task automatic t_fill_r2();
    for (int i = 0; i < 3200; i++) begin
      tick();
      wr_en = 1; wr_addr = 12'(i); wr_code = 7'((i*37 + 5) % 128);
      mem[i] = (i*37 + 5) % 128;
    end
    tick(); wr_en = 0;
    for (int i = 0; i < 12; i++) begin
      tick(); s_wr = 1; s_addr = 4'(i); s_code = 7'd127;
    end
    tick(); s_wr = 0;
    wait_frame();
    compare_frame("R1 R2 R3 R4", "full frame glyph pixels");
  endtask

  task automatic t_edge_r7();
    int lit = 0;
    for (int i = 0; i < 3; i++) begin
      do tick(); while (!(hx == 640 && vy == 4 + i*7));
      for (int k = 0; k < 4; k++) begin
        @(negedge clk); #2;
        if (pix !== 1'b0) lit++;
      end
    end
    check(lit == 0, "R7", lit, 0, "pixels past column 640");
  endtask

  task automatic t_frame_r5();
    wait_frame();
    fl = 14;
    wait_frame();
    fl = 25;
    compare_frame("R5", "frame after 14-line frame");
    check(vy == 0 && hx == 0, "R5", vy, 0, "bench position at frame seam");
  endtask

  task automatic t_blank_r6();
    blank_mode = 1;
    compare_frame("R6", "frame with periodic blank");
    blank_mode = 0;
  endtask

  task automatic t_write_r8();
    wait_frame();
    bad = 0;
    cmp_en = 1;
    do tick(); while (!(vy == 3 && hx == 100));
    for (int c = 0; c < 10; c++) begin
      wr_en = 1; wr_addr = 12'(80 + c); wr_code = 7'(c + 90);
      mem[80 + c] = c + 90;
      tick();
    end
    wr_en = 0;
    do tick(); while (!(vy == 5 && hx == 200));
    wr_en = 1; wr_addr = 12'd70; wr_code = 7'd3; mem[70] = 3;
    tick(); wr_en = 0;
    wait_frame();
    cmp_en = 0;
    check(bad == 0, "R8", fa, fe, $sformatf("writes during display, x=%0d y=%0d, %0d pixels", fx, fy, bad));
  endtask

  task automatic t_bottom_r7();
    do tick(); while (!(sx == 0 && sy == 0));
    s_dark_bad = 0; s_lit = 0; s_on = 1;
    do tick(); while (!(sx == 0 && sy == 0));
    s_on = 0;
    check(s_dark_bad == 0, "R7", s_dark_bad, 0, "small instance pixels below/right of text area");
    check(s_lit > 0, "R1", s_lit, 1, "small instance lit pixels inside area");
  endtask

  initial begin
    t_reset_r9();
    t_fill_r2();
    t_edge_r7();
    t_bottom_r7();
    t_frame_r5();
    t_blank_r6();
    t_write_r8();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(PERIOD*195000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule